// File: doc/BRIEF.md
# Masked Four-Line Interrupt Arbiter

This block watches a small set of level-sensitive interrupt request lines and, each time an evaluation strobe arrives, decides whether one of them becomes an interrupt exception. Lines are considered in ascending index order, and the lowest eligible index wins. A line is eligible when it is asserted and its per-line taken flag is clear, interrupts are globally open, and its index does not exceed a priority mask. Taking a line sets its taken flag and produces a one-cycle take pulse. The pulse carries the line index and an exception number, which is a fixed base plus the index.

When an eligible-looking request is held off, either by the disable bits or by the mask, a pending status bit is raised instead. The pending bit is recomputed at every evaluation. During a scan, each line passed over that is low, or already taken, has its taken flag cleared. A request held high is therefore taken on every second evaluation. Lines above the one taken in a scan are not visited, so their flags keep their value. A core's exception sequencer drives the strobe and consumes the take pulse.

Top module: `irq_line_arbiter`

## Requirements
- R1: After reset, takeValid and pendFlag are 0 and every per-line taken flag is clear, so an asserted line is taken at the first evaluation.
- R2: Without evalStrobe high at a rising clock edge, takeValid stays 0 and pendFlag and all taken flags keep their values whatever the other inputs do.
- R3: A line is a candidate when reqLines[i]=1 and its taken flag is 0. Of the candidates that may be taken, the one with the lowest index is taken, and at most one line is taken per evaluation.
- R4: No line is taken while intOff=1 or allOff=1. Interrupts are open only when both bits are 0.
- R5: A candidate with index i is taken only if i <= prioMask, with prioMask read as an unsigned number.
- R6: A take sets takeValid=1 for exactly the one cycle after the strobe edge, with takeLine equal to the taken index.
- R7: Each evaluation first clears pendFlag. pendFlag becomes 1 when a candidate is scanned but not taken, and it holds that value until the next evaluation.
- R8: Scanning a line that is low, or whose taken flag is already set, clears that flag. Lines with an index above the taken line are not scanned that evaluation. A line held high is therefore taken on every other evaluation.
- R9: With a take, excNum equals EXC_BASE + takeLine (default EXC_BASE = 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evalStrobe | input | 1 | Run one evaluation at this edge |
| reqLines | input | NUM_LINES (4) | Level-sensitive request lines, bit i is line i |
| prioMask | input | LINE_W (2) | Highest line index that may be taken |
| intOff | input | 1 | Interrupt disable |
| allOff | input | 1 | Disable-all |
| takeValid | output | 1 | One-cycle take pulse |
| takeLine | output | LINE_W (2) | Index of the taken line |
| excNum | output | EXC_W (8) | Exception number for the taken line |
| pendFlag | output | 1 | Candidate held off at last evaluation |

## Verification
Two things can happen to different lines in the same evaluation: one line is taken while another line's taken flag is cleared, or a line's flag is left as it was because the scan stopped below it. The bench provokes this by holding two or three lines high, with stale flags, across back-to-back evaluations. It then judges which index each later evaluation takes. The mask and the disable bits can also hold off a request in the same scan that would otherwise take a line. Those vectors are judged by pendFlag being set with no take pulse, and by the lower line winning once the block is opened.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic evalNow;   // perform a scan this edge
    logic gateOpen;  // global interrupt enable
  } arbCtl_t;

endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic    evalStrobe,
  input  logic    intOff,
  input  logic    allOff,
  output arbCtl_t ctl
);

  always_comb begin
    ctl.evalNow  = evalStrobe;
    ctl.gateOpen = ~intOff & ~allOff;
  end

endmodule

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int EXC_W     = 8,
  parameter int EXC_BASE  = 16,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  arbCtl_t              ctl,
  input  logic [NUM_LINES-1:0] reqLines,
  input  logic [LINE_W-1:0]    prioMask,
  output logic                 takeValid,
  output logic [LINE_W-1:0]    takeLine,
  output logic [EXC_W-1:0]     excNum,
  output logic                 pendFlag
);

  logic [NUM_LINES-1:0] activeQ;
  logic [NUM_LINES-1:0] activeNext;
  logic [NUM_LINES-1:0] candVec;
  logic [NUM_LINES-1:0] inRange;
  logic                 hitNow;
  logic [LINE_W-1:0]    hitIdx;
  logic                 pendNow;

  // Per-line candidate and mask qualification
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign candVec[g] = reqLines[g] & ~activeQ[g];
    assign inRange[g] = (LINE_W'(g) <= prioMask);
  end

  // Ascending scan; stops at first taken line
  always_comb begin
    activeNext = activeQ;
    hitNow     = 1'b0;
    hitIdx     = '0;
    pendNow    = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!hitNow) begin
        if (candVec[i]) begin
          if (ctl.gateOpen && inRange[i]) begin
            hitNow        = 1'b1;
            hitIdx        = LINE_W'(i);
            activeNext[i] = 1'b1;
          end else begin
            pendNow = 1'b1;
          end
        end else begin
          activeNext[i] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ   <= '0;
      takeValid <= 1'b0;
      takeLine  <= '0;
      excNum    <= '0;
      pendFlag  <= 1'b0;
    end else begin
      takeValid <= 1'b0;
      if (ctl.evalNow) begin
        activeQ   <= activeNext;
        takeValid <= hitNow;
        pendFlag  <= pendNow;
        if (hitNow) begin
          takeLine <= hitIdx;
          excNum   <= EXC_W'(EXC_BASE) + EXC_W'(hitIdx);
        end
      end
    end
  end

endmodule

// File: rtl/irq_line_arbiter.sv
module irq_line_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int EXC_W     = 8,
  parameter int EXC_BASE  = 16,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evalStrobe,
  input  logic [NUM_LINES-1:0] reqLines,
  input  logic [LINE_W-1:0]    prioMask,
  input  logic                 intOff,
  input  logic                 allOff,
  output logic                 takeValid,
  output logic [LINE_W-1:0]    takeLine,
  output logic [EXC_W-1:0]     excNum,
  output logic                 pendFlag
);

  arbCtl_t ctl;

  irq_arb_ctrl ctrl_i (
    .evalStrobe (evalStrobe),
    .intOff     (intOff),
    .allOff     (allOff),
    .ctl        (ctl)
  );

  irq_arb_datapath #(
    .NUM_LINES (NUM_LINES),
    .EXC_W     (EXC_W),
    .EXC_BASE  (EXC_BASE)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqLines  (reqLines),
    .prioMask  (prioMask),
    .takeValid (takeValid),
    .takeLine  (takeLine),
    .excNum    (excNum),
    .pendFlag  (pendFlag)
  );

endmodule

// File: rtl/irq_line_arbiter_chk.sv
module irq_line_arbiter_chk #(
  parameter int NUM_LINES = 4,
  parameter int LINE_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 evalStrobe,
  input logic [NUM_LINES-1:0] reqLines,
  input logic [LINE_W-1:0]    prioMask,
  input logic                 intOff,
  input logic                 allOff,
  input logic                 takeValid,
  input logic [LINE_W-1:0]    takeLine,
  input logic                 pendFlag
);

  // R2: no strobe, no take, pending held
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(evalStrobe) |-> (!takeValid && $stable(pendFlag)));

  // R3: taken line was requested at the strobe
  p_taken_requested_r3: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> ((($past(reqLines) >> takeLine) & 1) == 1));

  // R4: no take while disabled
  p_gate_closed_r4: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> (!$past(intOff) && !$past(allOff)));

  // R5: taken index within mask
  p_mask_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> (takeLine <= $past(prioMask)));

  // R6: take only follows a strobe
  p_take_after_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |-> $past(evalStrobe));

  // R7: a take and a pending flag never share an evaluation
  p_take_pend_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(takeValid && pendFlag));

endmodule

bind irq_line_arbiter irq_line_arbiter_chk #(
  .NUM_LINES (NUM_LINES),
  .LINE_W    (LINE_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .evalStrobe (evalStrobe),
  .reqLines   (reqLines),
  .prioMask   (prioMask),
  .intOff     (intOff),
  .allOff     (allOff),
  .takeValid  (takeValid),
  .takeLine   (takeLine),
  .pendFlag   (pendFlag)
);

// File: tb/irq_line_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_line_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evalStrobe = 1'b0;
  logic [3:0] reqLines = '0;
  logic [1:0] prioMask = '0;
  logic       intOff = 1'b0;
  logic       allOff = 1'b0;
  logic       takeValid;
  logic [1:0] takeLine;
  logic [7:0] excNum;
  logic       pendFlag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_line_arbiter dut_i (
    .clk(clk), .rstN(rstN), .evalStrobe(evalStrobe), .reqLines(reqLines),
    .prioMask(prioMask), .intOff(intOff), .allOff(allOff),
    .takeValid(takeValid), .takeLine(takeLine), .excNum(excNum),
    .pendFlag(pendFlag)
  );

  // {req[11:8], mask[7:6], intOff[5], allOff[4], expV[3], expLine[2:1], expPend[0]}
  localparam logic [11:0] VEC [14] = '{
    12'b0001_00_0_0_1_00_0, // R1 R3 first take of line 0
    12'b0001_00_0_0_0_00_0, // R8 held line flag cleared
    12'b0001_00_0_0_1_00_0, // R8 held line taken again
    12'b1000_11_0_0_1_11_0, // R5 top line under full mask
    12'b0100_01_0_0_0_00_1, // R5 R7 masked out -> pending
    12'b0100_10_0_0_1_10_0, // R7 pending cleared on take
    12'b0110_11_1_0_0_00_1, // R4 intOff blocks
    12'b0110_11_0_1_0_00_1, // R4 allOff blocks
    12'b0110_11_0_0_1_01_0, // R3 lowest wins
    12'b0111_11_0_0_1_00_0, // R3 R8 line 0 wins, upper flags kept
    12'b0110_11_0_0_1_10_0, // R8 line1 stale flag cleared, line2 taken
    12'b0000_11_0_0_0_00_0, // R8 all low
    12'b1111_00_1_1_0_00_1, // R4 both disables
    12'b1110_00_0_0_0_00_1  // R5 all above mask
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic evalOnce(input logic [3:0] r, input logic [1:0] m, input logic io, input logic ao);
    @(negedge clk);
    reqLines = r; prioMask = m; intOff = io; allOff = ao; evalStrobe = 1'b1;
    @(negedge clk);
    evalStrobe = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset takeValid", 32'(takeValid), 0);
    chk("R1 reset pendFlag", 32'(pendFlag), 0);
    rstN = 1'b1;

    for (int k = 0; k < 14; k++) begin
      logic [11:0] v;
      v = VEC[k];
      evalOnce(v[11:8], v[7:6], v[5], v[4]);
      chk($sformatf("R3 R6 vec%0d takeValid", k), 32'(takeValid), 32'(v[3]));
      chk($sformatf("R7 vec%0d pendFlag", k), 32'(pendFlag), 32'(v[0]));
      if (v[3]) begin
        chk($sformatf("R6 vec%0d takeLine", k), 32'(takeLine), 32'(v[2:1]));
        chk($sformatf("R9 vec%0d excNum", k), 32'(excNum), 32'(16 + v[2:1]));
        @(negedge clk);
        chk($sformatf("R6 vec%0d pulse width", k), 32'(takeValid), 0);
      end
    end

    // R2: inputs change with no strobe; pendFlag (1) held, no take
    @(negedge clk);
    reqLines = 4'b0001; prioMask = 2'b11; intOff = 0; allOff = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R2 idle takeValid", 32'(takeValid), 0);
      chk("R2 idle pendFlag", 32'(pendFlag), 1);
    end

    // R1: reset clears pending
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset pendFlag held", 32'(pendFlag), 0);
    chk("R1 reset takeValid", 32'(takeValid), 0);
    rstN = 1'b1;

    evalOnce(4'b0001, 2'b00, 0, 0);
    chk("R1 take after reset", 32'(takeValid), 1);
    // taken flag of line 0 now set; reset must clear it
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    evalOnce(4'b0001, 2'b00, 0, 0);
    chk("R1 flag cleared by reset", 32'(takeValid), 1);
    chk("R1 line after reset", 32'(takeLine), 0);

    report();
  end

endmodule